// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block holds the burst-control logic of a synchronous DRAM column path. A mode-set strobe loads a 14-bit mode word from the address bus. The low bits of that word set the burst length, the beat ordering and the read latency, and seven high option bits are kept as they are. After that, each read or write command takes a starting column from the low address bits. For every beat of the burst, the block produces one column address.

Beats follow sequential order or interleaved order, and both wrap inside the aligned burst-length window. A full-page burst walks round the whole column range until a stop input ends it. Read beats also travel through a short latency pipeline, which raises an output-enable and data-valid signal once the programmed read latency has passed. That signal drops as soon as the last read beat has left the pipeline. The DRAM array, banks and refresh are not modelled.

Top module: `sdram_burst_gen`

## Requirements
- R1: While reset is held, and after it is released, `col_vld_o`, `col_wr_o` and `dq_oe_o` are 0, and `opt_o` is 0. The mode word resets to all zeros, which means burst length 1, sequential order and latency 3.
- R2: When `mrs_i` is high at a clock edge, the mode word is loaded from `addr_i`, with bit layout [13:7] option, [6:4] latency code, [3] order and [2:0] length code. At all other times the mode word holds its value, and `opt_o` reports bits [13:7]. A command that arrives in the same cycle as `mrs_i` is ignored.
- R3: The length code selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Every other code gives 1 beat.
- R4: In sequential order (order bit 0), beat k carries the start column with its low log2(BL) bits replaced by (start+k) mod BL. The upper bits stay unchanged.
- R5: In interleaved order (order bit 1), beat k carries the start column with its low log2(BL) bits XORed with k.
- R6: A full-page burst steps sequentially and wraps modulo the column count (2^COL_W). The order bit has no effect on it, and it keeps running until `stop_i` is sampled high.
- R7: Beat k of a burst appears on `col_o`, with `col_vld_o` high, k+1 cycles after the edge that sampled the command. `col_wr_o` is 1 for write beats and 0 for read beats.
- R8: The latency code 010 gives 2 and any other code gives 3. For a read sampled at edge E, `dq_oe_o` is high from edge E+CL for exactly one cycle per read beat. In each of those cycles, `dq_col_o` carries the column of the matching beat.
- R9: `dq_oe_o` falls in the cycle after the last read beat leaves the pipeline. Write bursts never raise it.
- R10: A read or write command that arrives during a burst ends the current burst. The new burst starts from beat 0 at the new column in the next cycle.
- R11: When `stop_i` is high at an edge and no command is present, the running burst ends, and `col_vld_o` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_i | input | 1 | Mode-set strobe |
| rd_i | input | 1 | Read command |
| wr_i | input | 1 | Write command |
| stop_i | input | 1 | Burst stop |
| addr_i | input | 14 | Mode word, or start column in bits [COL_W-1:0] |
| col_o | output | COL_W | Column of the current beat |
| col_vld_o | output | 1 | A beat is active |
| col_wr_o | output | 1 | The current beat is a write |
| dq_oe_o | output | 1 | Read data valid and output enable after the latency |
| dq_col_o | output | COL_W | Column of the read beat whose data is on the bus |
| opt_o | output | 7 | Option bits of the mode word |

## Verification
The bench uses the default COL_W of 8, so the column range is 256. At that size a full-page burst of 300 beats wraps past column 255 back to 0 inside the run, and the bench can check every beat of it. An 8-beat window started near the top of that range exposes both the sequential wrap and the XOR pattern on bits that the window does not touch.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  // Field order is fixed: decoding depends on these positions.
  typedef struct packed {
    logic [6:0] opt;
    logic [2:0] lat;
    logic       ilv;
    logic [2:0] len;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
  localparam logic [2:0] LAT_TWO  = 3'b010;

endpackage

// File: rtl/bmr_mode_reg.sv
module bmr_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_i,
  input  logic [MODE_W-1:0] addr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             lat3_o,
  output logic [6:0]       opt_o
);

  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mrs_i) mode_d = mode_t'(addr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    full_o = 1'b0;
    mask_o = '0;
    unique case (mode_q.len)
      LEN_2:    mask_o = COL_W'(1);
      LEN_4:    mask_o = COL_W'(3);
      LEN_8:    mask_o = COL_W'(7);
      LEN_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:  mask_o = '0;
    endcase
  end

  assign ilv_o  = mode_q.ilv & ~full_o;
  assign lat3_o = (mode_q.lat != LAT_TWO);
  assign opt_o  = mode_q.opt;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_i |=> $stable(mode_q)); // R2

endmodule

// File: rtl/bcs_col_seq.sv
module bcs_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             lat3_i,
  output logic [COL_W-1:0] col_o,
  output logic             vld_o,
  output logic             wr_o,
  output logic             lat3_o
);

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic             full_q, full_d;
  logic             ilv_q, ilv_d;
  logic             lat3_q, lat3_d;
  logic [COL_W-1:0] start_q, start_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             cmd;
  logic             last_beat;
  logic [COL_W-1:0] offs;

  assign cmd       = rd_i | wr_i;
  assign last_beat = ~full_q & (cnt_q == mask_q);

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    full_d  = full_q;
    ilv_d   = ilv_q;
    lat3_d  = lat3_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    if (cmd) begin
      act_d   = 1'b1;
      wr_d    = ~rd_i;
      full_d  = full_i;
      ilv_d   = ilv_i;
      lat3_d  = lat3_i;
      start_d = start_i;
      mask_d  = mask_i;
      cnt_d   = '0;
    end else if (act_q) begin
      if (stop_i || last_beat) act_d = 1'b0;
      else                     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      lat3_q  <= 1'b1;
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      full_q  <= full_d;
      ilv_q   <= ilv_d;
      lat3_q  <= lat3_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
    end
  end

  assign offs   = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign col_o  = (start_q & ~mask_q) | (offs & mask_q);
  assign vld_o  = act_q;
  assign wr_o   = wr_q;
  assign lat3_o = lat3_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !full_q |-> cnt_q <= mask_q); // R3
  AST_FULL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && full_q && !stop_i && !cmd |=> act_q); // R6
  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> act_q && cnt_q == '0); // R10
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !cmd |=> !act_q); // R11

endmodule

// File: rtl/brl_rd_pipe.sv
module brl_rd_pipe #(
  parameter int COL_W   = 8,
  parameter int MAX_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             lat3_i,
  input  logic [COL_W-1:0] col_i,
  output logic             oe_o,
  output logic [COL_W-1:0] col_o
);

  localparam int NSTG = MAX_LAT - 1;

  logic [NSTG-1:0] st_vld_q, st_vld_d;
  logic [NSTG-1:0] st_lat3_q, st_lat3_d;
  logic [COL_W-1:0] st_col_q [NSTG];
  logic [COL_W-1:0] st_col_d [NSTG];
  logic [NSTG-1:0] hit;

  always_comb begin
    st_vld_d[0]  = vld_i;
    st_lat3_d[0] = lat3_i;
    st_col_d[0]  = col_i;
    for (int s = 1; s < NSTG; s++) begin
      st_vld_d[s]  = st_vld_q[s-1];
      st_lat3_d[s] = st_lat3_q[s-1];
      st_col_d[s]  = st_col_q[s-1];
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_vld_q[g]  <= 1'b0;
        st_lat3_q[g] <= 1'b0;
        st_col_q[g]  <= '0;
      end else begin
        st_vld_q[g]  <= st_vld_d[g];
        st_lat3_q[g] <= st_lat3_d[g];
        st_col_q[g]  <= st_col_d[g];
      end
    end
    // Stage g is the tap for latency g+2.
    assign hit[g] = st_vld_q[g] & (st_lat3_q[g] == (g == 1));
  end

  always_comb begin
    col_o = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (hit[s]) col_o = st_col_q[s];
    end
  end

  assign oe_o = |hit;

  AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> ($past(vld_i) || $past(vld_i, 2))); // R8
  AST_OE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i && !st_vld_q[0] |=> !oe_o); // R9

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             stop_i,
  input  logic [13:0]      addr_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             col_wr_o,
  output logic             dq_oe_o,
  output logic [COL_W-1:0] dq_col_o,
  output logic [6:0]       opt_o
);

  localparam int MAX_LAT = 3;

  logic             rst_meta_q, rst_sync_q;
  logic             rd_g, wr_g;
  logic [COL_W-1:0] mask;
  logic             full, ilv, lat3;
  logic             seq_vld, seq_wr, seq_lat3;
  logic [COL_W-1:0] seq_col;
  logic             pipe_vld;

  // Asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rd_g = rd_i & ~mrs_i;
  assign wr_g = wr_i & ~mrs_i;

  bmr_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .mrs_i  (mrs_i),
    .addr_i (addr_i),
    .mask_o (mask),
    .full_o (full),
    .ilv_o  (ilv),
    .lat3_o (lat3),
    .opt_o  (opt_o)
  );

  bcs_col_seq #(.COL_W(COL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rd_i    (rd_g),
    .wr_i    (wr_g),
    .stop_i  (stop_i),
    .start_i (addr_i[COL_W-1:0]),
    .mask_i  (mask),
    .full_i  (full),
    .ilv_i   (ilv),
    .lat3_i  (lat3),
    .col_o   (seq_col),
    .vld_o   (seq_vld),
    .wr_o    (seq_wr),
    .lat3_o  (seq_lat3)
  );

  assign pipe_vld = seq_vld & ~seq_wr;

  brl_rd_pipe #(.COL_W(COL_W), .MAX_LAT(MAX_LAT)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .vld_i  (pipe_vld),
    .lat3_i (seq_lat3),
    .col_i  (seq_col),
    .oe_o   (dq_oe_o),
    .col_o  (dq_col_o)
  );

  assign col_o     = seq_col;
  assign col_vld_o = seq_vld;
  assign col_wr_o  = seq_vld & seq_wr;

  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    col_wr_o && $past(col_wr_o) && $past(col_wr_o, 2) |-> !dq_oe_o); // R9

endmodule

// File: tb/sim_sdram_burst_gen.sv
module sim_sdram_burst_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mrs_i, rd_i, wr_i, stop_i;
  logic [13:0] addr_i;
  logic [7:0] col_o, dq_col_o;
  logic       col_vld_o, col_wr_o, dq_oe_o;
  logic [6:0] opt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sdram_burst_gen #(.COL_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mrs_i(mrs_i), .rd_i(rd_i), .wr_i(wr_i),
    .stop_i(stop_i), .addr_i(addr_i), .col_o(col_o), .col_vld_o(col_vld_o),
    .col_wr_o(col_wr_o), .dq_oe_o(dq_oe_o), .dq_col_o(dq_col_o), .opt_o(opt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] s, int k, int mask, bit il);
    logic [7:0] m, off;
    m   = mask[7:0];
    off = il ? (s ^ k[7:0]) : (s + k[7:0]);
    return (s & ~m) | (off & m);
  endfunction

  task automatic set_mode(input logic [6:0] opt, input logic [2:0] lat,
                          input bit il, input logic [2:0] len);
    @(negedge clk);
    mrs_i = 1'b1; addr_i = {opt, lat, il, len};
    @(negedge clk);
    mrs_i = 1'b0; addr_i = '0;
  endtask

  // Issue a command; returns at the sample point where beat 0 is visible.
  task automatic issue(input bit rd, input logic [7:0] col);
    @(negedge clk);
    rd_i = rd; wr_i = ~rd; addr_i = {6'h2B, col};
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0; addr_i = '0;
  endtask

  task automatic burst(input bit rd, input logic [7:0] s, input int len,
                       input int mask, input bit il, input int lat, input string req);
    issue(rd, s);
    for (int m = 1; m <= len + 4; m++) begin
      bit ev = (m <= len);
      bit eo = rd && (m >= lat) && (m < lat + len);
      chk(col_vld_o == ev, {req, " R7 vld"}, col_vld_o, ev);
      if (ev) begin
        chk(col_o == exp_col(s, m - 1, mask, il), req, col_o, exp_col(s, m - 1, mask, il));
        chk(col_wr_o == !rd, {req, " R7 wr"}, col_wr_o, !rd);
      end
      chk(dq_oe_o == eo, {req, " R8/R9 oe"}, dq_oe_o, eo);
      if (eo)
        chk(dq_col_o == exp_col(s, m - lat, mask, il), {req, " R8 dq_col"},
            dq_col_o, exp_col(s, m - lat, mask, il));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mrs_i = 0; rd_i = 0; wr_i = 0; stop_i = 0; addr_i = '0;
    repeat (3) @(negedge clk);
    chk(col_vld_o == 0 && dq_oe_o == 0 && col_wr_o == 0, "R1 in reset", col_vld_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(col_vld_o == 0 && dq_oe_o == 0, "R1 after release", dq_oe_o, 0);
    chk(opt_o == 7'h0, "R1 opt", opt_o, 0);
    burst(1'b1, 8'h09, 1, 0, 0, 3, "R1 default mode");
  endtask

  task automatic t_seq;
    set_mode(7'h11, 3'b010, 0, 3'b010);
    burst(1'b1, 8'h06, 4, 3, 0, 2, "R4 seq BL4");
    set_mode(7'h11, 3'b011, 0, 3'b011);
    burst(1'b1, 8'hFD, 8, 7, 0, 3, "R4 seq BL8");
    set_mode(7'h11, 3'b010, 0, 3'b001);
    burst(1'b1, 8'h33, 2, 1, 0, 2, "R3 BL2");
  endtask

  task automatic t_ilv;
    set_mode(7'h22, 3'b011, 1, 3'b011);
    burst(1'b1, 8'hC5, 8, 7, 1, 3, "R5 ilv BL8");
    set_mode(7'h22, 3'b010, 1, 3'b010);
    burst(1'b1, 8'h4E, 4, 3, 1, 2, "R5 ilv BL4");
  endtask

  task automatic t_write;
    set_mode(7'h05, 3'b010, 0, 3'b011);
    burst(1'b0, 8'hFA, 8, 7, 0, 2, "R9 write BL8");
  endtask

  task automatic t_reserved;
    set_mode(7'h05, 3'b111, 0, 3'b101);
    burst(1'b1, 8'h77, 1, 0, 0, 3, "R3/R8 reserved codes");
  endtask

  task automatic t_mode_hold;
    set_mode(7'h55, 3'b010, 0, 3'b010);
    chk(opt_o == 7'h55, "R2 opt load", opt_o, 7'h55);
    burst(1'b1, 8'h20, 4, 3, 0, 2, "R2 mode kept");
    chk(opt_o == 7'h55, "R2 opt hold", opt_o, 7'h55);
    // Command together with mode set is ignored.
    @(negedge clk);
    mrs_i = 1'b1; rd_i = 1'b1; addr_i = {7'h0A, 3'b010, 1'b0, 3'b000};
    @(negedge clk);
    mrs_i = 1'b0; rd_i = 1'b0; addr_i = '0;
    chk(col_vld_o == 0, "R2 cmd with mrs ignored", col_vld_o, 0);
    chk(opt_o == 7'h0A, "R2 opt reload", opt_o, 7'h0A);
  endtask

  task automatic t_full;
    set_mode(7'h01, 3'b010, 1, 3'b111);
    issue(1'b1, 8'd250);
    for (int m = 1; m <= 300; m++) begin
      chk(col_vld_o == 1 && col_o == 8'((250 + m - 1) % 256), "R6 full page",
          col_o, (250 + m - 1) % 256);
      if (m == 300) stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
    end
    chk(col_vld_o == 0, "R6 stop ends page", col_vld_o, 0);
    chk(dq_oe_o == 1, "R8 last page beat", dq_oe_o, 1);
    @(negedge clk);
    chk(dq_oe_o == 0, "R9 oe off", dq_oe_o, 0);
  endtask

  task automatic t_stop;
    set_mode(7'h01, 3'b010, 0, 3'b011);
    issue(1'b1, 8'h10);
    chk(col_vld_o && col_o == 8'h10, "R11 beat0", col_o, 8'h10);
    @(negedge clk);
    chk(col_vld_o && col_o == 8'h11, "R11 beat1", col_o, 8'h11);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(col_vld_o == 0, "R11 stopped", col_vld_o, 0);
    chk(dq_oe_o == 1 && dq_col_o == 8'h11, "R11 last data", dq_col_o, 8'h11);
    @(negedge clk);
    chk(dq_oe_o == 0, "R9 oe after stop", dq_oe_o, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_interrupt;
    set_mode(7'h01, 3'b010, 0, 3'b011);
    issue(1'b1, 8'h05);
    for (int m = 1; m <= 3; m++) begin
      chk(col_vld_o && col_o == 8'(5 + m - 1), "R10 read beats", col_o, 5 + m - 1);
      if (m < 3) @(negedge clk);
    end
    wr_i = 1'b1; addr_i = {6'h00, 8'h40};
    @(negedge clk);
    wr_i = 1'b0; addr_i = '0;
    for (int k = 0; k < 8; k++) begin
      chk(col_vld_o && col_wr_o && col_o == 8'(8'h40 + k), "R10 new burst", col_o, 8'h40 + k);
      if (k == 0) chk(dq_oe_o && dq_col_o == 8'h07, "R10 last read data", dq_col_o, 8'h07);
      else        chk(dq_oe_o == 0, "R10 oe off", dq_oe_o, 0);
      @(negedge clk);
    end
    chk(col_vld_o == 0, "R10 end", col_vld_o, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_ilv();
    t_write();
    t_reserved();
    t_mode_hold();
    t_full();
    t_stop();
    t_interrupt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule